// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Converter Scan Controller

This block is the digital side of a multi-channel successive-approximation analog-to-digital converter. Software reaches it through a byte-wide register port. That port holds one control/status byte and a result area that can only be read. Once software sets the start bit, the controller waits for the next strobe of a divided conversion clock. It then drives the sample-and-hold enable for a fixed window and resolves a 10-bit code one bit per strobe, most significant bit first. For each bit it presents a trial code to the external DAC and reads back a single comparator bit. The finished code goes into the result register of that channel.

In scan mode the controller visits channels 0 up to a programmed last channel within the selected group of four. It raises the end flag after each pass, wraps back to channel 0 and keeps running while the start bit stays set. The results remain valid and readable during the run. In single mode it converts one channel, raises the end flag and clears the start bit itself.

Clearing the start bit aborts the run at once and writes no result. An interrupt output is high while the end flag and the interrupt enable are both set.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, every result reads 0, and irq, sample_en and trial_code are all 0.
- R2: Control bit 5 (start) and bit 6 (interrupt enable) take the written value. Bit 7 (end flag) is cleared by writing 0 to it, and writing 1 to it leaves it unchanged.
- R3: Control bit 4 (1 = scan, 0 = single), bit 3 (channel group) and bits 1:0 (last channel in scan mode, or the channel in single mode) accept a write only while start is 0. Bit 2 always reads 0.
- R4: The conversion strobe fires once every DIV clocks, so that sequencer steps land on clock edges whose count since reset release is a multiple of DIV. sample_en first rises on the first such edge after the start write, which is 1 to DIV cycles later depending on strobe phase.
- R5: sample_en stays high for exactly SAMPLE_TICKS*DIV cycles per channel. During that window mux_sel equals {group, channel}, and trial_code is 0 outside the approximation phase.
- R6: Approximation takes RES_BITS decisions, MSB first, one per strobe. A comparator input of 1 means the analog level is at or above the trial code, and the bit is kept. For an input level v the stored result equals v.
- R7: Result n reads at address 8+2n as bits 9:2, and at address 9+2n with bits 1:0 placed in data bits 7:6 and the other data bits 0.
- R8: In scan mode the channels 0..last of the group are converted in order, and each result goes to its own register. The end flag is set when the last channel finishes, and the scan wraps to channel 0 while start is 1.
- R9: In single mode the selected channel's result appears (SAMPLE_TICKS+RES_BITS)*DIV cycles after sampling began. At that point the end flag sets and start clears, and the other results are left untouched.
- R10: irq is high exactly when the end flag and the interrupt enable are both 1.
- R11: Writing start = 0 during a conversion returns the controller to idle on that edge (sample_en and trial_code are 0), begins no further sampling and changes no result register.
- R12: Writes to result addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address (0 control, 8..15 results) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | End-of-conversion interrupt |
| cmp_hi | input | 1 | Comparator result: analog level at or above trial code |
| mux_sel | output | 3 | Analog channel select {group, channel} |
| sample_en | output | 1 | Sample-and-hold enable |
| trial_code | output | 10 | Trial code for the external DAC |

## Verification
On every cycle, assertions check the following:
- sampling starts only on a strobe edge;
- a cleared start bit forces the engine idle on the next edge and freezes every result;
- the mode, group and channel fields hold still while running;
- the end flag rises only at the close of a pass;
- the active channel never passes the programmed last channel;
- single mode clears its own start bit.

Only the bench scenarios can show the rest:
- the exact synchronization delay for each strobe phase;
- the length of the sampling window;
- the correctness of the approximated codes at the range boundaries;
- the channel order across a wrap;
- the byte layout of the results;
- the interrupt gating.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_SAMPLE = 2'd1,
        ENG_CONV   = 2'd2
    } eng_state_e;

    // Control byte bit positions (software-visible layout)
    localparam int CTRL_DONE_BIT  = 7;
    localparam int CTRL_IEN_BIT   = 6;
    localparam int CTRL_START_BIT = 5;
    localparam int CTRL_SCAN_BIT  = 4;
    localparam int CTRL_GROUP_BIT = 3;

endpackage

// File: rtl/adc_strobe_div.sv
module adc_strobe_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
    import adc_scan_pkg::*;
#(
    parameter int RES_BITS     = 10,
    parameter int SAMPLE_TICKS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                enable,
    input  logic                cont,
    input  logic                cmp_hi,
    output logic                sample_en,
    output logic [RES_BITS-1:0] trial_code,
    output logic                busy,
    output logic                conv_done,
    output logic [RES_BITS-1:0] conv_code
);
    localparam int SCW = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
    localparam int BW  = $clog2(RES_BITS);
    localparam logic [RES_BITS-1:0] ONE     = RES_BITS'(1);
    localparam logic [RES_BITS-1:0] MSB_ONE = ONE << (RES_BITS - 1);

    typedef struct packed {
        eng_state_e          st;
        logic [SCW-1:0]      scnt;
        logic [BW-1:0]       bit_idx;
        logic [RES_BITS-1:0] code;
    } eng_t;

    eng_t q, n;
    logic [RES_BITS-1:0] decided;

    always_comb begin
        n         = q;
        conv_done = 1'b0;
        conv_code = '0;
        decided   = cmp_hi ? q.code : (q.code & ~(ONE << q.bit_idx));
        if (!enable) begin
            n.st      = ENG_IDLE;
            n.scnt    = '0;
            n.bit_idx = '0;
            n.code    = '0;
        end else begin
            unique case (q.st)
                ENG_IDLE: begin
                    if (tick) begin
                        n.st   = ENG_SAMPLE;
                        n.scnt = '0;
                    end
                end
                ENG_SAMPLE: begin
                    if (tick) begin
                        if (q.scnt == SCW'(SAMPLE_TICKS - 1)) begin
                            n.st      = ENG_CONV;
                            n.bit_idx = BW'(RES_BITS - 1);
                            n.code    = MSB_ONE;
                        end else begin
                            n.scnt = q.scnt + SCW'(1);
                        end
                    end
                end
                ENG_CONV: begin
                    if (tick) begin
                        if (q.bit_idx == '0) begin
                            conv_done = 1'b1;
                            conv_code = decided;
                            n.st      = cont ? ENG_SAMPLE : ENG_IDLE;
                            n.scnt    = '0;
                            n.code    = '0;
                        end else begin
                            n.bit_idx = q.bit_idx - BW'(1);
                            n.code    = decided | (ONE << (q.bit_idx - BW'(1)));
                        end
                    end
                end
                default: n.st = ENG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ENG_IDLE, scnt: '0, bit_idx: '0, code: '0};
        else        q <= n;
    end

    assign sample_en  = (q.st == ENG_SAMPLE);
    assign trial_code = (q.st == ENG_CONV) ? q.code : '0;
    assign busy       = (q.st != ENG_IDLE);

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !busy) else $error("engine not idle after stop"); // R11

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int CH_PER_GROUP = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            busy,
    input  logic                            conv_done,
    input  logic                            scan,
    input  logic [$clog2(CH_PER_GROUP)-1:0] chan_fld,
    output logic [$clog2(CH_PER_GROUP)-1:0] ch_idx,
    output logic                            pass_end
);
    localparam int CHW = $clog2(CH_PER_GROUP);

    logic [CHW-1:0] ch_d, ch_q, ch_first;
    logic           last_ch;

    always_comb begin
        ch_first = scan ? '0 : chan_fld;
        last_ch  = !scan || (ch_q == chan_fld);
        pass_end = conv_done && last_ch;
        ch_d     = ch_q;
        if (!busy)          ch_d = ch_first;
        else if (conv_done) ch_d = (scan && !last_ch) ? ch_q + CHW'(1) : ch_first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign ch_idx = ch_q;

    AST_CH_WITHIN_PASS: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (ch_q <= chan_fld)) else $error("channel beyond last"); // R8

endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int CH_PER_GROUP = 4,
    parameter int RES_BITS     = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(CH_PER_GROUP)+1:0] addr,
    input  logic [7:0]                      wdata,
    output logic [7:0]                      rdata,
    input  logic                            pass_end,
    input  logic                            res_we,
    input  logic [$clog2(CH_PER_GROUP)-1:0] res_idx,
    input  logic [RES_BITS-1:0]             res_code,
    output logic                            run,
    output logic                            scan,
    output logic                            group,
    output logic [$clog2(CH_PER_GROUP)-1:0] chan_fld,
    output logic                            irq
);
    localparam int CHW = $clog2(CH_PER_GROUP);
    localparam int AW  = CHW + 2;

    typedef struct packed {
        logic                                   done;
        logic                                   ien;
        logic                                   start;
        logic                                   scan;
        logic                                   group;
        logic [CHW-1:0]                         chan;
        logic [CH_PER_GROUP-1:0][RES_BITS-1:0]  res;
    } regs_t;

    regs_t q, n;
    logic  ctrl_wr;
    logic  unused_wbits;
    logic [CHW-1:0] rd_idx;
    logic [15:0]    rd_wide;
    logic [7:0]     ctrl_byte;

    assign ctrl_wr      = wr_en && (addr == '0);
    assign run          = q.start && !(ctrl_wr && !wdata[CTRL_START_BIT]);
    assign unused_wbits = ^wdata[2:CHW];

    always_comb begin
        n = q;
        if (ctrl_wr) begin
            n.done  = q.done & wdata[CTRL_DONE_BIT];
            n.ien   = wdata[CTRL_IEN_BIT];
            n.start = wdata[CTRL_START_BIT];
            if (!q.start) begin
                n.scan  = wdata[CTRL_SCAN_BIT];
                n.group = wdata[CTRL_GROUP_BIT];
                n.chan  = wdata[CHW-1:0];
            end
        end
        if (res_we) n.res[res_idx] = res_code;
        if (pass_end) begin
            n.done = 1'b1;
            if (!q.scan) n.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        ctrl_byte                 = '0;
        ctrl_byte[CTRL_DONE_BIT]  = q.done;
        ctrl_byte[CTRL_IEN_BIT]   = q.ien;
        ctrl_byte[CTRL_START_BIT] = q.start;
        ctrl_byte[CTRL_SCAN_BIT]  = q.scan;
        ctrl_byte[CTRL_GROUP_BIT] = q.group;
        ctrl_byte[CHW-1:0]        = q.chan;
        rd_idx  = addr[AW-2:1];
        rd_wide = 16'(q.res[rd_idx]) << (16 - RES_BITS);
        if (addr[AW-1])        rdata = addr[0] ? rd_wide[7:0] : rd_wide[15:8];
        else if (addr == '0)   rdata = ctrl_byte;
        else                   rdata = '0;
    end

    assign scan     = q.scan;
    assign group    = q.group;
    assign chan_fld = q.chan;
    assign irq      = q.done & q.ien;

    AST_DONE_ONLY_AT_PASS_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(q.done) |-> $past(pass_end)) else $error("end flag without pass end"); // R8
    AST_RESULTS_FROZEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) !run |=> $stable(q.res)) else $error("result changed while stopped"); // R11
    AST_CFG_FROZEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n) q.start |=> $stable({q.scan, q.group, q.chan})) else $error("config changed while running"); // R3
    AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (pass_end && !q.scan) |=> !q.start) else $error("single mode kept start"); // R9

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
    parameter int RES_BITS     = 10,
    parameter int CH_PER_GROUP = 4,
    parameter int DIV          = 4,
    parameter int SAMPLE_TICKS = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(CH_PER_GROUP)+1:0] addr,
    input  logic [7:0]                      wdata,
    output logic [7:0]                      rdata,
    output logic                            irq,
    input  logic                            cmp_hi,
    output logic [$clog2(CH_PER_GROUP):0]   mux_sel,
    output logic                            sample_en,
    output logic [RES_BITS-1:0]             trial_code
);
    localparam int CHW = $clog2(CH_PER_GROUP);

    logic                tick, run, scan, group, busy, conv_done, pass_end;
    logic [CHW-1:0]      chan_fld, ch_idx;
    logic [RES_BITS-1:0] conv_code;

    adc_strobe_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    adc_sar_engine #(.RES_BITS(RES_BITS), .SAMPLE_TICKS(SAMPLE_TICKS)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(run), .cont(scan),
        .cmp_hi(cmp_hi), .sample_en(sample_en), .trial_code(trial_code),
        .busy(busy), .conv_done(conv_done), .conv_code(conv_code)
    );

    adc_scan_seq #(.CH_PER_GROUP(CH_PER_GROUP)) u_seq (
        .clk(clk), .rst_n(rst_n), .busy(busy), .conv_done(conv_done),
        .scan(scan), .chan_fld(chan_fld), .ch_idx(ch_idx), .pass_end(pass_end)
    );

    adc_scan_regs #(.CH_PER_GROUP(CH_PER_GROUP), .RES_BITS(RES_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pass_end(pass_end), .res_we(conv_done), .res_idx(ch_idx),
        .res_code(conv_code), .run(run), .scan(scan), .group(group),
        .chan_fld(chan_fld), .irq(irq)
    );

    assign mux_sel = {group, ch_idx};

    AST_SAMPLE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sample_en) |-> $past(tick)) else $error("sampling began off strobe"); // R4

endmodule

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;
    localparam int RES = 10;
    localparam int CH  = 4;
    localparam int DIV = 4;
    localparam int ST  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, cmp_hi, sample_en;
    logic [2:0] mux_sel;
    logic [9:0] trial_code;
    logic [9:0] vin [8];

    int checks = 0, fails = 0, ecnt = 0, cyc = 0;
    int exp_res [4];
    int log_ch [64];
    int log_n = 0;
    bit se_prev = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_scan_ctrl #(.RES_BITS(RES), .CH_PER_GROUP(CH), .DIV(DIV), .SAMPLE_TICKS(ST)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .cmp_hi(cmp_hi), .mux_sel(mux_sel),
        .sample_en(sample_en), .trial_code(trial_code)
    );

    assign cmp_hi = (vin[mux_sel] >= trial_code);

    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    always @(negedge clk) begin
        if (sample_en && !se_prev && log_n < 64) begin
            log_ch[log_n] = int'(mux_sel);
            log_n = log_n + 1;
        end
        se_prev = sample_en;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        addr = 4'(a);
        #1 v = int'(rdata);
    endtask

    task automatic rd_res(input int n, output int v);
        int hi, lo;
        rd(8 + 2*n, hi);
        rd(9 + 2*n, lo);
        v = hi * 4 + lo / 64;
    endtask

    task automatic wait_irq(input int maxc, output bit ok);
        ok = 1'b0;
        for (int k = 0; k < maxc; k++) begin
            @(negedge clk);
            if (irq) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        int v, w, m, cnt, hi, lo, g, ch, val, last, first0;
        bit ok;
        int bnd [4];
        bnd[0] = 0; bnd[1] = 1023; bnd[2] = 512; bnd[3] = 511;
        for (int k = 0; k < 8; k++) vin[k] = '0;
        for (int k = 0; k < 4; k++) exp_res[k] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v);
        check(v == 0, "R1 control after reset", v, 0);
        check(irq == 0 && sample_en == 0 && trial_code == 0, "R1 outputs idle", int'(trial_code), 0);
        for (int k = 0; k < 4; k++) begin
            rd_res(k, v);
            check(v == 0, "R1 result after reset", v, 0);
        end

        // R3 config write while stopped, bit 2 reads 0; R2 end flag cannot be set by writing 1
        wr(0, 8'h5B);
        rd(0, v);
        check(v == 8'h5B, "R3 config write stopped", v, 8'h5B);
        wr(0, 8'h9E);
        rd(0, v);
        check(v == 8'h1A, "R2 R3 flag not settable, bit2 zero", v, 8'h1A);
        wr(0, 8'h00);

        // Single-mode sweep across all channels and strobe phases: R4 R5 R6 R7 R9 R10
        for (int i = 0; i < 8; i++) begin
            ch = i % 4; g = i / 4;
            val = (i < 4) ? bnd[i] : (i * 149 + 77) % 1024;
            vin[g*4 + ch] = 10'(val);
            while ((ecnt % DIV) != ((i * 3) % DIV)) @(negedge clk);
            wr_en = 1'b1; addr = 4'd0; wdata = 8'(32'h20 | (g << 3) | ch);
            @(negedge clk);
            wr_en = 1'b0;
            w = ecnt;
            cnt = 0;
            while (!sample_en && cnt < 100) begin @(negedge clk); cnt++; end
            m = ecnt;
            check(m == (w / DIV + 1) * DIV, "R4 sync delay to strobe", m - w, (w / DIV + 1) * DIV - w);
            check(int'(mux_sel) == g*4 + ch, "R5 mux select in window", int'(mux_sel), g*4 + ch);
            cnt = 0;
            while (sample_en && cnt < 100) begin
                if (trial_code != 0) check(1'b0, "R5 trial zero while sampling", int'(trial_code), 0);
                cnt++; @(negedge clk);
            end
            check(cnt == ST * DIV, "R5 sample window length", cnt, ST * DIV);
            do rd(0, v); while ((v & 32'h20) != 0 && ecnt < m + 500);
            check(ecnt == m + (ST + RES) * DIV, "R9 single conversion time", ecnt - m, (ST + RES) * DIV);
            check((v & 32'hA0) == 32'h80, "R9 end flag set start cleared", v & 32'hA0, 32'h80);
            check(irq == 0, "R10 irq low while disabled", int'(irq), 0);
            rd_res(ch, v);
            check(v == val, "R6 approximated code", v, val);
            exp_res[ch] = val;
            for (int k = 0; k < 4; k++) begin
                rd_res(k, v);
                check(v == exp_res[k], "R9 other results untouched", v, exp_res[k]);
            end
            if (i == 1 || i == 3) begin
                rd(8 + 2*ch, hi); rd(9 + 2*ch, lo);
                check(hi == (val >> 2), "R7 high byte layout", hi, val >> 2);
                check(lo == ((val & 3) << 6), "R7 low byte layout", lo, (val & 3) << 6);
            end
            if (i == 0) begin
                wr(0, 8'hC0);
                rd(0, v);
                check((v & 32'h80) != 0, "R2 writing 1 keeps end flag", v & 32'h80, 32'h80);
                check(irq == 1, "R10 irq with flag and enable", int'(irq), 1);
                wr(0, 8'h40);
                check(irq == 0, "R10 irq drops with flag", int'(irq), 0);
            end
            wr(0, 8'h00);
        end

        // Scan passes over every last-channel setting: R8 R3 R10
        for (last = 0; last < 4; last++) begin
            g = last % 2;
            for (int c = 0; c < 4; c++) vin[g*4 + c] = 10'(((g*4 + c) * 263 + last * 97 + 5) % 1024);
            log_n = 0;
            wr(0, 32'h70 | (g << 3) | last);
            wait_irq(2000, ok);
            check(ok, "R8 end flag after first pass", int'(ok), 1);
            for (int c = 0; c <= last; c++) begin
                rd_res(c, v);
                check(v == int'(vin[g*4 + c]), "R8 scan result", v, int'(vin[g*4 + c]));
                exp_res[c] = int'(vin[g*4 + c]);
            end
            for (int c = last + 1; c < 4; c++) begin
                rd_res(c, v);
                check(v == exp_res[c], "R8 unscanned result kept", v, exp_res[c]);
            end
            wr(0, 8'h60);
            rd(0, v);
            check(v == (32'h70 | (g << 3) | last), "R3 config ignored while running", v, 32'h70 | (g << 3) | last);
            check(irq == 0, "R10 irq cleared with flag", int'(irq), 0);
            wait_irq(2000, ok);
            check(ok, "R8 end flag after wrap", int'(ok), 1);
            check(log_n >= 2 * (last + 1), "R8 samples logged", log_n, 2 * (last + 1));
            for (int j = 0; j < 2 * (last + 1); j++)
                check(log_ch[j] == g*4 + (j % (last + 1)), "R8 channel order", log_ch[j], g*4 + (j % (last + 1)));
            wr(0, 8'h40);
            check(sample_en == 0 && trial_code == 0, "R11 stop returns idle", int'(sample_en), 0);
            wr(0, 8'h00);
        end

        // Abort partway through channel 1: R11
        for (int c = 0; c < 4; c++) vin[c] = 10'((c * 181 + 700) % 1024);
        log_n = 0;
        wr(0, 8'h73);
        cnt = 0;
        while (log_n < 2 && cnt < 500) begin @(negedge clk); cnt++; end
        repeat (20) @(negedge clk);
        wr(0, 8'h40);
        check(sample_en == 0 && trial_code == 0, "R11 abort idle at once", int'(trial_code), 0);
        repeat (200) @(negedge clk);
        check(log_n == 2, "R11 no sampling after abort", log_n, 2);
        rd(0, v);
        check((v & 32'hA0) == 0, "R11 no flag no start after abort", v & 32'hA0, 0);
        first0 = int'(vin[0]);
        rd_res(0, v);
        check(v == first0, "R11 finished channel kept", v, first0);
        exp_res[0] = first0;
        for (int c = 1; c < 4; c++) begin
            rd_res(c, v);
            check(v == exp_res[c], "R11 aborted results unchanged", v, exp_res[c]);
        end

        // R12 result area is read-only
        wr(8, 8'hAA);
        wr(9, 8'hFF);
        rd_res(0, v);
        check(v == exp_res[0], "R12 result write ignored", v, exp_res[0]);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule